// File: doc/BRIEF.md
# Infrared Subcarrier Transmit Modulator

This block turns a serial bit stream into the drive signal for an infrared LED. Logic-0 bits are sent as bursts of subcarrier pulses and logic-1 bits leave the line dark. A framing stage upstream presents each bit on `tx_bit` and pulses `bit_strobe` for one clock cycle at the start of every bit time. `tx_active` frames the whole transmission.

A speed-select bit chooses between two settings:

- **Low speed.** The subcarrier period is programmable in reference-clock cycles, and the pulse width comes from a table in the microsecond range.
- **High speed.** The subcarrier is fixed at 500 kHz, and the pulse width comes from a table of sub-microsecond entries.

A two-bit mode field decides how a zero bit is rendered: one unbroken pulse train for a run of zeros, or a fixed burst of six or eight pulses. Every time interval is counted in cycles of a single reference clock. The `REF_MHZ` parameter gives that clock's frequency in MHz.

The configuration inputs are registered before use. An illegal setting raises `cfg_err` and silences the LED line.

Top module: `irtx_sc_modulator`

## Requirements
- R1: While `tx_active` is low, `tx_out` is low from the next clock cycle on, and any pulse train in progress is abandoned.
- R2: A strobe carrying a logic-1 bit drives `tx_out` low from the next cycle, and no pulse occurs until the next zero-bit strobe.
- R3: With `pulse_mode` 00 or 11 (continuous), a zero-bit strobe starts pulsing in the next cycle if no train is running. The pulses continue without a break, and without a phase restart, across any number of consecutive zero bits.
- R4: With `pulse_mode` 01, each zero bit produces exactly 6 subcarrier pulses starting at the bit strobe, after which `tx_out` stays low for the rest of the bit.
- R5: With `pulse_mode` 10, each zero bit produces exactly 8 subcarrier pulses, followed by a low line for the rest of the bit.
- R6: In burst modes, every zero-bit strobe restarts the burst at pulse one. A bit shorter than its burst truncates that burst.
- R7: With `hs_sel` = 0, the subcarrier period is `freq_div` reference cycles. The pulse high time for `width_code` 010, 011, 100 and 101 is 6, 7, 9 and 10.6 µs respectively, rounded to whole reference cycles.
- R8: With `hs_sel` = 1, the period is fixed at 2 µs (500 kHz) and `freq_div` is ignored. Codes k = 0 to 5 give a high time of (k+1)·0.25 µs, rounded to whole cycles.
- R9: The reserved width codes raise `cfg_err` and keep `tx_out` low:
  - at low speed: 000, 001, 110 and 111;
  - at high speed: 110 and 111.
- R10: At low speed, a `freq_div` below 2, or one not larger than the selected high time, raises `cfg_err` and keeps `tx_out` low.
- R11: Configuration inputs take effect one cycle after they are applied. `cfg_err` and `tx_out` are registered outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_active | input | 1 | High while a transmission is in progress |
| bit_strobe | input | 1 | One-cycle pulse marking the start of a bit time |
| tx_bit | input | 1 | Bit value, sampled with `bit_strobe` |
| pulse_mode | input | 2 | 00/11 continuous, 01 six pulses, 10 eight pulses |
| hs_sel | input | 1 | 1: fixed 500 kHz and high-speed width table; 0: programmable low speed |
| width_code | input | 3 | Pulse width table index |
| freq_div | input | CNT_W | Low-speed subcarrier period in reference cycles |
| tx_out | output | 1 | LED drive, active high |
| cfg_err | output | 1 | Illegal width code or divisor |

## Verification
The bench counts rising edges and high cycles of `tx_out` over the window of each bit.

- **Burst length.** A burst that stops one pulse early or late changes the edge count. Back-to-back short zero bits show whether the burst restarts on each strobe or carries on from the previous bit.
- **Continuous mode.** Two zero bits in a row must yield one evenly spaced train. A design that re-phased at every strobe would add a spurious pulse.
- **High speed.** The spacing between the first two edges must match the fixed period even when `freq_div` holds an unrelated value.
- **Configuration and idle.** Reserved codes and too-small divisors must leave the line dark. Dropping `tx_active` mid-pulse must stop the train at once, not at the end of the pulse.

// File: rtl/irtx_pkg.sv
package irtx_pkg;

  typedef enum logic [1:0] {
    PM_CONT  = 2'b00,
    PM_SIX   = 2'b01,
    PM_EIGHT = 2'b10,
    PM_CONT2 = 2'b11
  } pmode_t;

  // Low-speed widths are held in tenths of a microsecond.
  function automatic int lo_width_cyc(input int code, input int ref_mhz);
    case (code)
      2:       return (ref_mhz * 60 + 5) / 10;
      3:       return (ref_mhz * 70 + 5) / 10;
      4:       return (ref_mhz * 90 + 5) / 10;
      5:       return (ref_mhz * 106 + 5) / 10;
      default: return 0;
    endcase
  endfunction

  function automatic bit lo_code_ok(input int code);
    return (code >= 2) && (code <= 5);
  endfunction

  // High-speed widths step in quarter microseconds.
  function automatic int hi_width_cyc(input int code, input int ref_mhz);
    if (code <= 5) return (ref_mhz * (code + 1) + 2) / 4;
    return 0;
  endfunction

  function automatic bit hi_code_ok(input int code);
    return code <= 5;
  endfunction

endpackage

// File: rtl/irtx_cfg_decode.sv
module irtx_cfg_decode #(
  parameter int REF_MHZ = 8,
  parameter int CNT_W   = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hs_sel,
  input  logic [2:0]       width_code,
  input  logic [CNT_W-1:0] freq_div,
  output logic [CNT_W-1:0] period_q,
  output logic [CNT_W-1:0] high_q,
  output logic             err_q
);

  localparam int NCODE = 8;
  localparam logic [CNT_W-1:0] FIXED_PERIOD = CNT_W'(2 * REF_MHZ);

  logic [CNT_W-1:0] lo_tab [NCODE];
  logic [CNT_W-1:0] hi_tab [NCODE];
  logic [NCODE-1:0] lo_ok;
  logic [NCODE-1:0] hi_ok;

  for (genvar g = 0; g < NCODE; g++) begin : g_tab
    assign lo_tab[g] = CNT_W'(irtx_pkg::lo_width_cyc(g, REF_MHZ));
    assign hi_tab[g] = CNT_W'(irtx_pkg::hi_width_cyc(g, REF_MHZ));
    assign lo_ok[g]  = irtx_pkg::lo_code_ok(g);
    assign hi_ok[g]  = irtx_pkg::hi_code_ok(g);
  end

  logic [CNT_W-1:0] per_d;
  logic [CNT_W-1:0] hi_d;
  logic             err_d;

  always_comb begin
    if (hs_sel) begin
      per_d = FIXED_PERIOD;
      hi_d  = hi_tab[width_code];
      err_d = !hi_ok[width_code];
    end else begin
      per_d = freq_div;
      hi_d  = lo_tab[width_code];
      err_d = !lo_ok[width_code] || (freq_div < CNT_W'(2)) || (freq_div <= hi_d);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      period_q <= FIXED_PERIOD;
      high_q   <= '0;
      err_q    <= 1'b0;
    end else begin
      period_q <= per_d;
      high_q   <= hi_d;
      err_q    <= err_d;
    end
  end

  a_r8_fixed_period: assert property (@(posedge clk) disable iff (rst)
    hs_sel |=> (period_q == FIXED_PERIOD));

  a_r10_small_divisor: assert property (@(posedge clk) disable iff (rst)
    (!hs_sel && (freq_div < CNT_W'(2))) |=> err_q);

  a_r9_reserved_high: assert property (@(posedge clk) disable iff (rst)
    (hs_sel && (width_code[2:1] == 2'b11)) |=> err_q);

endmodule

// File: rtl/irtx_pulse_gen.sv
module irtx_pulse_gen #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tx_active,
  input  logic             bit_strobe,
  input  logic             tx_bit,
  input  logic [1:0]       pulse_mode,
  input  logic [CNT_W-1:0] period,
  input  logic [CNT_W-1:0] high_time,
  input  logic             cfg_err,
  output logic             tx_out
);

  import irtx_pkg::*;

  localparam int PC_W = 4;

  logic             run_q, run_d;
  logic [CNT_W-1:0] phase_q, phase_d;
  logic [PC_W-1:0]  pcnt_q, pcnt_d;
  logic             burst;
  logic [PC_W-1:0]  target;
  logic             start, stop, wrap;

  assign burst  = (pulse_mode == PM_SIX) || (pulse_mode == PM_EIGHT);
  assign target = (pulse_mode == PM_SIX) ? PC_W'(6) : PC_W'(8);
  assign start  = bit_strobe && tx_active && !tx_bit;
  assign stop   = !tx_active || cfg_err || (bit_strobe && tx_bit);
  assign wrap   = phase_q >= (period - CNT_W'(1));

  always_comb begin
    run_d   = run_q;
    phase_d = phase_q;
    pcnt_d  = pcnt_q;
    if (stop) begin
      run_d   = 1'b0;
      phase_d = '0;
      pcnt_d  = '0;
    end else if (start && (burst || !run_q)) begin
      run_d   = 1'b1;
      phase_d = '0;
      pcnt_d  = '0;
    end else if (run_q) begin
      if (wrap) begin
        phase_d = '0;
        if (pcnt_q != {PC_W{1'b1}}) pcnt_d = pcnt_q + PC_W'(1);
        if (burst && (pcnt_q >= target - PC_W'(1))) run_d = 1'b0;
      end else begin
        phase_d = phase_q + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q   <= 1'b0;
      phase_q <= '0;
      pcnt_q  <= '0;
      tx_out  <= 1'b0;
    end else begin
      run_q   <= run_d;
      phase_q <= phase_d;
      pcnt_q  <= pcnt_d;
      tx_out  <= run_d && (phase_d < high_time);
    end
  end

  a_r1_idle_low: assert property (@(posedge clk) disable iff (rst)
    !tx_active |=> !tx_out);

  a_r2_one_dark: assert property (@(posedge clk) disable iff (rst)
    (bit_strobe && tx_bit) |=> !tx_out);

  a_r9_err_mutes: assert property (@(posedge clk) disable iff (rst)
    cfg_err |=> !tx_out);

  a_r3_zero_lights: assert property (@(posedge clk) disable iff (rst)
    (start && !cfg_err) |=> tx_out);

  a_r4_burst_bound: assert property (@(posedge clk) disable iff (rst)
    (run_q && burst) |-> (pcnt_q < target));

endmodule

// File: rtl/irtx_sc_modulator.sv
module irtx_sc_modulator #(
  parameter int REF_MHZ = 8,
  parameter int CNT_W   = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tx_active,
  input  logic             bit_strobe,
  input  logic             tx_bit,
  input  logic [1:0]       pulse_mode,
  input  logic             hs_sel,
  input  logic [2:0]       width_code,
  input  logic [CNT_W-1:0] freq_div,
  output logic             tx_out,
  output logic             cfg_err
);

  logic [CNT_W-1:0] period_q;
  logic [CNT_W-1:0] high_q;
  logic [1:0]       mode_q;

  always_ff @(posedge clk) begin
    if (rst) mode_q <= 2'b00;
    else     mode_q <= pulse_mode;
  end

  irtx_cfg_decode #(.REF_MHZ(REF_MHZ), .CNT_W(CNT_W)) i_cfg (
    .clk        (clk),
    .rst        (rst),
    .hs_sel     (hs_sel),
    .width_code (width_code),
    .freq_div   (freq_div),
    .period_q   (period_q),
    .high_q     (high_q),
    .err_q      (cfg_err)
  );

  irtx_pulse_gen #(.CNT_W(CNT_W)) i_gen (
    .clk        (clk),
    .rst        (rst),
    .tx_active  (tx_active),
    .bit_strobe (bit_strobe),
    .tx_bit     (tx_bit),
    .pulse_mode (mode_q),
    .period     (period_q),
    .high_time  (high_q),
    .cfg_err    (cfg_err),
    .tx_out     (tx_out)
  );

endmodule

// File: tb/test_irtx_sc_modulator.sv
`timescale 1ns/1ps
module test_irtx_sc_modulator;

  localparam int CNT_W = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tx_active = 1'b0;
  logic bit_strobe = 1'b0;
  logic tx_bit = 1'b1;
  logic [1:0] pulse_mode = 2'b01;
  logic hs_sel = 1'b0;
  logic [2:0] width_code = 3'b010;
  logic [CNT_W-1:0] freq_div = 16'd200;
  logic tx_out;
  logic cfg_err;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  int edges = 0;
  int highs = 0;
  int t_first = -1;
  int t_second = -1;
  logic prev_out = 1'b0;

  always #2 clk = ~clk;

  irtx_sc_modulator #(.REF_MHZ(8), .CNT_W(CNT_W)) i_irtx_sc_modulator (
    .clk(clk), .rst(rst), .tx_active(tx_active), .bit_strobe(bit_strobe),
    .tx_bit(tx_bit), .pulse_mode(pulse_mode), .hs_sel(hs_sel),
    .width_code(width_code), .freq_div(freq_div), .tx_out(tx_out), .cfg_err(cfg_err)
  );

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (tx_out && !prev_out) begin
      edges = edges + 1;
      if (t_first < 0) t_first = cyc;
      else if (t_second < 0) t_second = cyc;
    end
    if (tx_out) highs = highs + 1;
    prev_out = tx_out;
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clear_mon();
    edges = 0; highs = 0; t_first = -1; t_second = -1;
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic send_bit(input logic b, input int len);
    bit_strobe = 1'b1; tx_bit = b;
    tick();
    bit_strobe = 1'b0;
    repeat (len - 1) tick();
  endtask

  task automatic setup(input logic hs, input logic [2:0] code, input int div, input logic [1:0] m);
    hs_sel = hs; width_code = code; freq_div = CNT_W'(div); pulse_mode = m;
    repeat (3) tick();
  endtask

  task automatic t_reset();
    repeat (4) tick();
    rst = 1'b0;
    tick();
    check("R11 reset tx_out", int'(tx_out), 0);
    check("R11 reset cfg_err", int'(cfg_err), 0);
    tx_active = 1'b1;
  endtask

  task automatic t_six();
    setup(1'b0, 3'b010, 200, 2'b01);
    clear_mon();
    send_bit(1'b0, 1400);
    check("R4 six edges", edges, 6);
    check("R7 six high cycles (6us=48)", highs, 288);
    check("R7 low-speed period", t_second - t_first, 200);
    check("R4 dark tail", int'(tx_out), 0);
  endtask

  task automatic t_eight();
    setup(1'b0, 3'b101, 200, 2'b10);
    clear_mon();
    send_bit(1'b0, 1800);
    check("R5 eight edges", edges, 8);
    check("R7 10.6us width=85", highs, 680);
  endtask

  task automatic t_cont();
    setup(1'b0, 3'b011, 200, 2'b00);
    send_bit(1'b1, 50);
    clear_mon();
    send_bit(1'b0, 1000);
    send_bit(1'b0, 1000);
    check("R3 continuous edges", edges, 10);
    check("R3 continuous high (7us=56)", highs, 560);
    clear_mon();
    send_bit(1'b1, 400);
    check("R2 one bit edges", edges, 0);
    check("R2 one bit high", highs, 0);
  endtask

  task automatic t_cont_alt();
    setup(1'b0, 3'b100, 200, 2'b11);
    clear_mon();
    send_bit(1'b0, 400);
    send_bit(1'b0, 400);
    send_bit(1'b1, 10);
    check("R3 mode 11 edges", edges, 4);
    check("R7 9us width=72", highs, 288);
  endtask

  task automatic t_ones();
    setup(1'b0, 3'b010, 200, 2'b01);
    clear_mon();
    send_bit(1'b1, 300);
    send_bit(1'b1, 300);
    check("R2 ones in burst mode", edges, 0);
  endtask

  task automatic t_restart();
    setup(1'b0, 3'b010, 200, 2'b01);
    clear_mon();
    send_bit(1'b0, 500);
    send_bit(1'b0, 500);
    check("R6 truncated bursts edges", edges, 6);
    check("R6 truncated bursts high", highs, 288);
    send_bit(1'b1, 20);
  endtask

  task automatic t_high_speed();
    setup(1'b1, 3'b011, 200, 2'b01);
    check("R8 code 011 legal", int'(cfg_err), 0);
    clear_mon();
    send_bit(1'b0, 200);
    check("R8 hs edges", edges, 6);
    check("R8 hs width 1us=8", highs, 48);
    check("R8 fixed period 16", t_second - t_first, 16);
    setup(1'b1, 3'b000, 3, 2'b10);
    check("R8 code 000 legal at high speed", int'(cfg_err), 0);
    clear_mon();
    send_bit(1'b0, 200);
    check("R8 hs code 000 width 2", highs, 16);
    setup(1'b1, 3'b111, 200, 2'b01);
    check("R9 hs code 111 err", int'(cfg_err), 1);
  endtask

  task automatic t_reserved();
    setup(1'b0, 3'b000, 200, 2'b01);
    check("R9 low code 000 err", int'(cfg_err), 1);
    clear_mon();
    send_bit(1'b0, 1400);
    check("R9 muted edges", edges, 0);
    setup(1'b0, 3'b110, 200, 2'b00);
    check("R9 low code 110 err", int'(cfg_err), 1);
    setup(1'b0, 3'b010, 40, 2'b00);
    check("R10 divisor below width err", int'(cfg_err), 1);
    clear_mon();
    send_bit(1'b0, 400);
    check("R10 muted edges", edges, 0);
    setup(1'b0, 3'b010, 1, 2'b00);
    check("R10 divisor 1 err", int'(cfg_err), 1);
    setup(1'b0, 3'b010, 200, 2'b00);
    check("R11 err clears", int'(cfg_err), 0);
  endtask

  task automatic t_idle();
    setup(1'b0, 3'b010, 200, 2'b00);
    send_bit(1'b0, 10);
    check("R3 pulsing before idle", int'(tx_out), 1);
    tx_active = 1'b0;
    tick();
    #1;
    check("R1 low after idle", int'(tx_out), 0);
    clear_mon();
    repeat (600) tick();
    check("R1 no edges while idle", edges, 0);
    send_bit(1'b0, 300);
    check("R1 zero strobe while idle ignored", edges, 0);
    tx_active = 1'b1;
  endtask

  initial begin
    t_reset();
    t_six();
    t_eight();
    t_cont();
    t_cont_alt();
    t_ones();
    t_restart();
    t_high_speed();
    t_reserved();
    t_idle();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    wait (cyc >= 150000);
    checks++;
    fails++;
    $display("FAIL watchdog: actual %0d expected below 150000 cycles", cyc);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule